// File: doc/BRIEF.md
# Type-C Configuration Channel Line Status Monitor

This block turns the digitized voltages of the two Type-C configuration channel (CC) lines into a 3-bit termination status code per line. It bases the reading on the termination the port applies locally: a pull-up (source side), a pull-down (sink side), or none. The block holds the last status of each line. When a new sample moves either line to a different code, it raises a one-cycle change event, which the alert logic above it latches.

The two voltages enter as a valid/ready stream. A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high. The producer must keep `smp_valid` and both voltages steady until that edge. The block pulls `smp_ready` low to hold samples back in two cases: while the lines settle after a termination change, and in any cycle where `term_sel` differs from the applied termination. The termination select and the status outputs are plain level signals.

When the termination changes, both stored statuses drop to open, and no samples are taken for one millisecond of clock cycles (`CLK_HZ/1000`). A further change inside that window starts the full delay again.

Top module: `cc_status_monitor`

## Requirements
- R1: After reset the applied termination is none (code 0), both status outputs read 0, `cc_change` is low and `smp_ready` is high.
- R2: With a pull-down applied (`term_sel` = 2), an accepted voltage of 1230 mV or more classifies as 4 (3.0 A advertised). A voltage of 660 mV up to 1229 mV classifies as 3 (1.5 A advertised).
- R3: With a pull-down applied, an accepted voltage below 660 mV classifies as 2 (default current) if it is at least 200 mV, and as 0 (open) otherwise.
- R4: With a pull-up applied (`term_sel` = 1), an accepted voltage of 2600 mV or more classifies as 0 (open), below 200 mV as 1 (Ra), and anything between as 2 (sink present). Codes 3 and 4 never appear under a pull-up.
- R5: With no termination applied (`term_sel` = 0, or the unused code 3), both statuses stay 0 whatever voltages are sampled.
- R6: On the clock edge where `term_sel` differs from the applied termination, the new value is applied and both statuses become 0. No `cc_change` event comes from this forcing.
- R7: Presenting the termination that is already applied does nothing: `smp_ready` stays high and the stored statuses are unchanged.
- R8: After the edge that applies a termination change, `smp_ready` stays low for exactly `CLK_HZ/1000` cycles. A further change inside that window restarts the full count.
- R9: For an accepted sample where either line's code differs from its stored code, the stored code is updated. `cc_change` is then high for exactly the one cycle after the accepting edge.
- R10: An accepted sample that leaves both codes unchanged raises no event. Without an accepted sample and without a termination change, the statuses hold.
- R11: `smp_ready` is low during the settle window and in any cycle where `term_sel` differs from the applied termination. A held `smp_valid` is accepted on the first edge after the window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_sel | input | 2 | Requested local termination: 0 none, 1 pull-up, 2 pull-down, 3 treated as none |
| smp_valid | input | 1 | A voltage pair is offered |
| smp_ready | output | 1 | The block takes the offered pair on this edge |
| cc1_mv | input | MV_W | CC1 voltage in millivolts |
| cc2_mv | input | MV_W | CC2 voltage in millivolts |
| cc1_status | output | 3 | Stored CC1 status code |
| cc2_status | output | 3 | Stored CC2 status code |
| cc_change | output | 1 | One-cycle event: a stored status changed |

## Verification
The bench places voltages exactly on each threshold and one millivolt below it. An off-by-one comparison therefore shows up as a wrong code at 200, 660, 1230 or 2600 mV. It counts the settle window cycle by cycle and restarts it midway. A design that shortened the window, or that kept counting from the first change, would accept a sample too early. It also repeats samples that leave the codes unchanged and re-presents the applied termination. A design that raised events on every sample, or that reset the statuses on a repeated request, would show a spurious `cc_change` or lost status codes.

// File: rtl/cc_mon_pkg.sv
package cc_mon_pkg;

  typedef enum logic [1:0] {
    TERM_NONE   = 2'd0,
    TERM_PULLUP = 2'd1,
    TERM_PULLDN = 2'd2,
    TERM_SPARE  = 2'd3
  } term_e;

  typedef enum logic [2:0] {
    ST_OPEN = 3'd0,
    ST_RA   = 3'd1,
    ST_SNK  = 3'd2,
    ST_1A5  = 3'd3,
    ST_3A0  = 3'd4
  } ccst_e;

  localparam int NUM_LINES = 2;

endpackage

// File: rtl/cc_line_classify.sv
module cc_line_classify
  import cc_mon_pkg::*;
#(
  parameter int MV_W     = 13,
  parameter int NC_MV    = 2600,
  parameter int RA_MV    = 200,
  parameter int SRC15_MV = 660,
  parameter int SRC30_MV = 1230
) (
  input  logic [1:0]      term,
  input  logic [MV_W-1:0] mv,
  output logic [2:0]      code
);

  localparam logic [MV_W-1:0] NC_LIM    = MV_W'(NC_MV);
  localparam logic [MV_W-1:0] RA_LIM    = MV_W'(RA_MV);
  localparam logic [MV_W-1:0] SRC15_LIM = MV_W'(SRC15_MV);
  localparam logic [MV_W-1:0] SRC30_LIM = MV_W'(SRC30_MV);

  ccst_e res;

  always_comb begin
    res = ST_OPEN;
    case (term_e'(term))
      TERM_PULLUP: begin
        if (mv >= NC_LIM)      res = ST_OPEN;
        else if (mv < RA_LIM)  res = ST_RA;
        else                   res = ST_SNK;
      end
      TERM_PULLDN: begin
        if (mv >= SRC30_LIM)      res = ST_3A0;
        else if (mv >= SRC15_LIM) res = ST_1A5;
        else if (mv >= RA_LIM)    res = ST_SNK;
        else                      res = ST_OPEN;
      end
      default: res = ST_OPEN;
    endcase
  end

  assign code = res;

endmodule

// File: rtl/cc_settle_timer.sv
module cc_settle_timer #(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic busy
);

  localparam int SETTLE = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int CW     = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8
  restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == LOAD));

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(restart));

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);

endmodule

// File: rtl/cc_status_monitor.sv
module cc_status_monitor
  import cc_mon_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int MV_W     = 13,
  parameter int NC_MV    = 2600,
  parameter int RA_MV    = 200,
  parameter int SRC15_MV = 660,
  parameter int SRC30_MV = 1230
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      term_sel,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [MV_W-1:0] cc1_mv,
  input  logic [MV_W-1:0] cc2_mv,
  output logic [2:0]      cc1_status,
  output logic [2:0]      cc2_status,
  output logic            cc_change
);

  logic [1:0] term_q;
  logic       term_chg;
  logic       busy;
  logic       accept;
  logic       chg_q;

  logic [MV_W-1:0] mv_in   [NUM_LINES];
  logic [2:0]      code_nx [NUM_LINES];
  logic [2:0]      st_q    [NUM_LINES];
  logic [NUM_LINES-1:0] diff;

  assign mv_in[0] = cc1_mv;
  assign mv_in[1] = cc2_mv;

  assign term_chg  = (term_sel != term_q);
  assign smp_ready = !busy && !term_chg;
  assign accept    = smp_valid && smp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        term_q <= TERM_NONE;
    else if (term_chg) term_q <= term_sel;
  end

  cc_settle_timer #(.CLK_HZ(CLK_HZ)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (term_chg),
    .busy    (busy)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    cc_line_classify #(
      .MV_W(MV_W), .NC_MV(NC_MV), .RA_MV(RA_MV),
      .SRC15_MV(SRC15_MV), .SRC30_MV(SRC30_MV)
    ) u_cls (
      .term (term_q),
      .mv   (mv_in[g]),
      .code (code_nx[g])
    );

    assign diff[g] = (code_nx[g] != st_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)                 st_q[g] <= ST_OPEN;
      else if (term_chg)          st_q[g] <= ST_OPEN;
      else if (accept && diff[g]) st_q[g] <= code_nx[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= accept && (|diff);
  end

  assign cc1_status = st_q[0];
  assign cc2_status = st_q[1];
  assign cc_change  = chg_q;

  // R6
  force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_chg |=> (cc1_status == 3'd0 && cc2_status == 3'd0 && !cc_change));

  // R9
  change_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_change |-> (cc1_status != $past(cc1_status) || cc2_status != $past(cc2_status)));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !term_chg) |=> ($stable(cc1_status) && $stable(cc2_status) && !cc_change));

  // R11
  settle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !smp_ready);

  // R5
  none_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q == TERM_NONE || term_q == TERM_SPARE) |-> (cc1_status == 3'd0 && cc2_status == 3'd0));

  // R4
  pullup_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q == TERM_PULLUP) |-> (cc1_status <= 3'd2 && cc2_status <= 3'd2));

endmodule

// File: tb/cc_status_monitor_bench.sv
module cc_status_monitor_bench;

  localparam int CLK_HZ = 8_000_000;
  localparam int SETTLE = CLK_HZ / 1000;
  localparam int MV_W   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] term_sel = 2'd0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [MV_W-1:0] cc1_mv = '0;
  logic [MV_W-1:0] cc2_mv = '0;
  logic [2:0] cc1_status, cc2_status;
  logic cc_change;

  always #2 clk = ~clk;

  cc_status_monitor #(.CLK_HZ(CLK_HZ), .MV_W(MV_W)) u_cc_status_monitor (
    .clk(clk), .rst_n(rst_n), .term_sel(term_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .cc1_mv(cc1_mv), .cc2_mv(cc2_mv),
    .cc1_status(cc1_status), .cc2_status(cc2_status),
    .cc_change(cc_change)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] exp_q[$];
  logic mon_take = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: take flag sampled from pre-edge values
  always @(posedge clk) mon_take <= smp_valid && smp_ready;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mon_take) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected accept", 1, 0);
        end else begin
          logic [6:0] e;
          e = exp_q.pop_front();
          chk(cc1_status == e[5:3], "R2/R3/R4/R5 cc1 code", cc1_status, e[5:3]);
          chk(cc2_status == e[2:0], "R2/R3/R4/R5 cc2 code", cc2_status, e[2:0]);
          chk(cc_change == e[6], "R9/R10 change event", cc_change, e[6]);
        end
      end else if (cc_change !== 1'b0) begin
        chk(0, "R9 event outside accept cycle", cc_change, 0);
      end
    end
  end

  task automatic send(input int v1, input int v2, input int e1, input int e2,
                      input bit ec, output int waited);
    @(negedge clk);
    cc1_mv = MV_W'(v1);
    cc2_mv = MV_W'(v2);
    smp_valid = 1'b1;
    waited = 0;
    while (!smp_ready) begin
      @(negedge clk);
      waited++;
    end
    exp_q.push_back({ec, 3'(e1), 3'(e2)});
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic put(input int v1, input int v2, input int e1, input int e2, input bit ec);
    int w;
    send(v1, v2, e1, e2, ec, w);
  endtask

  task automatic set_term(input logic [1:0] t);
    @(negedge clk);
    term_sel = t;
  endtask

  task automatic measure(input string req);
    int n;
    n = 0;
    @(negedge clk);
    chk(cc1_status == 0 && cc2_status == 0, "R6 forced open", {cc1_status, cc2_status}, 0);
    chk(cc_change == 0, "R6 no event on forcing", cc_change, 0);
    while (!smp_ready && n < SETTLE + 10) begin
      n++;
      @(negedge clk);
    end
    chk(n == SETTLE, req, n, SETTLE);
  endtask

  initial begin
    int w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cc1_status == 0 && cc2_status == 0, "R1 reset status", {cc1_status, cc2_status}, 0);
    chk(cc_change == 0, "R1 reset event", cc_change, 0);
    chk(smp_ready == 1, "R1 reset ready", smp_ready, 1);

    // R5 no termination
    put(3000, 100, 0, 0, 0);

    // pull-down
    set_term(2'd2);
    measure("R8 settle length pull-down");
    put(1300, 700, 4, 3, 1);     // R2
    put(1230, 1229, 4, 3, 0);    // R2 boundaries, R10 no change
    put(660, 659, 3, 2, 1);      // R2 / R3
    put(200, 199, 2, 0, 1);      // R3
    put(0, 5000, 0, 4, 1);       // R3 / R2

    // R7 same termination again
    set_term(2'd2);
    @(negedge clk);
    chk(smp_ready == 1, "R7 ready kept", smp_ready, 1);
    chk(cc1_status == 0 && cc2_status == 4, "R7 status kept", {cc1_status, cc2_status}, 4);

    // R8 restart during settle
    set_term(2'd1);
    repeat (5) @(negedge clk);
    chk(smp_ready == 0, "R11 ready low while settling", smp_ready, 0);
    set_term(2'd2);
    measure("R8 restart gives full window");

    // pull-up with back-pressure on a held sample
    set_term(2'd1);
    send(2600, 2599, 0, 2, 1, w);  // R4
    chk(w == SETTLE, "R11 held sample waits full window", w, SETTLE);
    put(199, 200, 1, 2, 1);        // R4
    put(0, 4095, 1, 0, 1);         // R4
    put(4095, 2599, 0, 2, 1);      // R4
    put(4095, 2599, 0, 2, 0);      // R10

    // back to no termination
    set_term(2'd0);
    measure("R8 settle length none");
    put(1000, 100, 0, 0, 0);       // R5

    // spare code behaves as none
    set_term(2'd3);
    measure("R8 settle length spare");
    put(1300, 300, 0, 0, 0);       // R5

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all samples observed", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule